// File: doc/BRIEF.md
# Sign/Log Step-Counting ADC Controller

This block holds the digital sequencing for a serial logarithmic analog-to-digital converter built from a switched-capacitor decay stage. When a sample strobe arrives, it precharges the reference (master) capacitor and empties the slave capacitor. It then runs repeated charge-sharing steps. Each step multiplies the master voltage by a fixed ratio d < 1. The block counts the steps until a magnitude comparator reports that the decayed voltage has reached or dropped below the held input. The frozen step count is the log-magnitude field of the output code. The polarity comparator, read at the end of precharge, supplies the sign bit.

The comparators, capacitors and sample/hold stay outside the block and appear as two asynchronous digital inputs. Both inputs pass through a multi-flop synchronizer. The magnitude decision is taken only in the last cycle of the precharge phase and of each slave-discharge phase. In those cycles the analog node has been still for longer than the synchronizer latency. Very small inputs would never trip the comparator, so the count saturates at its all-ones value. The phase lengths are parameters. The longest conversion, about 2^CODE_W steps of SHARE_CYC+DUMP_CYC+2 cycles each, must fit inside the 16 kHz sample period of the system clock.

Top module: `slog_adc_ctrl`

## Requirements
- R1: While reset is active and right after it, all three phase enables, `code_vld_o` and `code_o` are 0.
- R2: A strobe accepted while idle raises `precharge_en_o` and `discharge_en_o` together on the next clock edge. Both stay high for exactly PRE_CYC cycles (4 by default).
- R3: `share_en_o` is never high in a cycle where `precharge_en_o` or `discharge_en_o` is high. At least one cycle with all three low separates every share pulse from the phases on either side of it.
- R4: `code_o[CODE_W-1:0]` equals the number of share pulses issued in that conversion. That number is the smallest k for which the decayed level d^k is at or below |x|, as reported by the magnitude comparator (1 = at or below the held input).
- R5: If the comparator has not tripped by the time the count reaches 2^CODE_W-1, the conversion ends. The code is 2^CODE_W-1 and no further share pulse is issued.
- R6: `code_o[CODE_W]` is the sign bit: 1 when the polarity comparator (1 = negative input) is high at the end of precharge.
- R7: `code_vld_o` is a single-cycle pulse, issued once per conversion. `code_o` changes only in the cycle where `code_vld_o` is high and holds its value otherwise.
- R8: A strobe that arrives while a conversion runs is ignored. There is no restart, no extra precharge, no extra result, and the code does not change.
- R9: An input at or above full scale (comparator already tripped after precharge) gives magnitude code 0 with no share pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sample_stb_i | input | 1 | Start-of-sample strobe, one cycle |
| sign_cmp_i | input | 1 | Polarity comparator, asynchronous, 1 = negative input |
| mag_cmp_i | input | 1 | Magnitude comparator, asynchronous, 1 = capacitor level at or below held input |
| precharge_en_o | output | 1 | Connects master capacitor to the reference |
| share_en_o | output | 1 | Connects master and slave capacitors |
| discharge_en_o | output | 1 | Shorts the slave capacitor |
| code_o | output | CODE_W+1 | {sign, log-magnitude count} |
| code_vld_o | output | 1 | One-cycle pulse marking a new code |

## Verification
The bench models the master capacitor as a real number that is reset to 1.0 on precharge and multiplied by d=0.9 on every share pulse. It drives the comparator from that model. Random inputs drawn on a log scale between step boundaries exercise counts across the whole code range, with random sign. Inputs placed exactly on d^k and just above or below it separate a correct at-or-below decision from an off-by-one in the evaluation point. Full-scale, over-range, zero and tiny inputs separate the immediate-trip path from saturation. Conversions with a second strobe in flight show whether a busy controller restarts or emits a second result.

// File: rtl/slog_pkg.sv
package slog_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_PRE   = 3'd1,
    PH_GAP_A = 3'd2,
    PH_SHARE = 3'd3,
    PH_GAP_B = 3'd4,
    PH_DUMP  = 3'd5
  } phase_e;
endpackage

// File: rtl/slog_rst_sync.sv
module slog_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/slog_sync.sv
module slog_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (STAGES == 1) begin : g_single
      logic [W-1:0] stg_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= d_i;
      end
      assign q_o = stg_q;
    end else begin : g_chain
      logic [STAGES*W-1:0] stg_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= {stg_q[(STAGES-1)*W-1:0], d_i};
      end
      assign q_o = stg_q[STAGES*W-1 -: W];
    end
  endgenerate
endmodule

// File: rtl/slog_step_cnt.sv
module slog_step_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         at_max_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign at_max_o = &cnt_q;
  assign cnt_en   = clr_i || (inc_i && !at_max_o);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/slog_phase_seq.sv
module slog_phase_seq #(
  parameter int PRE_CYC   = 4,
  parameter int SHARE_CYC = 2,
  parameter int DUMP_CYC  = 3,
  parameter int GAP_CYC   = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic cont_i,
  output logic accept_o,
  output logic eval_o,
  output logic eval_pre_o,
  output logic pre_en_o,
  output logic share_en_o,
  output logic dump_en_o
);
  import slog_pkg::*;

  localparam int LONG_AB = (PRE_CYC > SHARE_CYC) ? PRE_CYC : SHARE_CYC;
  localparam int LONG_CD = (DUMP_CYC > GAP_CYC) ? DUMP_CYC : GAP_CYC;
  localparam int LONGEST = (LONG_AB > LONG_CD) ? LONG_AB : LONG_CD;
  localparam int TW      = $clog2(LONGEST + 1);

  phase_e        st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          last;
  logic          pre_q, share_q, dump_q;

  assign last = (tmr_q == '0);

  always_comb begin
    st_d     = st_q;
    tmr_d    = tmr_q;
    accept_o = 1'b0;
    eval_o   = 1'b0;
    unique case (st_q)
      PH_IDLE: begin
        if (start_i) begin
          accept_o = 1'b1;
          st_d     = PH_PRE;
          tmr_d    = TW'(PRE_CYC - 1);
        end
      end
      PH_PRE, PH_DUMP: begin
        if (!last) begin
          tmr_d = tmr_q - 1'b1;
        end else begin
          eval_o = 1'b1;
          if (cont_i) begin
            st_d  = PH_GAP_A;
            tmr_d = TW'(GAP_CYC - 1);
          end else begin
            st_d = PH_IDLE;
          end
        end
      end
      PH_GAP_A: begin
        if (!last) tmr_d = tmr_q - 1'b1;
        else begin
          st_d  = PH_SHARE;
          tmr_d = TW'(SHARE_CYC - 1);
        end
      end
      PH_SHARE: begin
        if (!last) tmr_d = tmr_q - 1'b1;
        else begin
          st_d  = PH_GAP_B;
          tmr_d = TW'(GAP_CYC - 1);
        end
      end
      PH_GAP_B: begin
        if (!last) tmr_d = tmr_q - 1'b1;
        else begin
          st_d  = PH_DUMP;
          tmr_d = TW'(DUMP_CYC - 1);
        end
      end
      default: st_d = PH_IDLE;
    endcase
  end

  assign eval_pre_o = eval_o && (st_q == PH_PRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PH_IDLE;
      tmr_q   <= '0;
      pre_q   <= 1'b0;
      share_q <= 1'b0;
      dump_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      tmr_q   <= tmr_d;
      pre_q   <= (st_d == PH_PRE);
      share_q <= (st_d == PH_SHARE);
      dump_q  <= (st_d == PH_PRE) || (st_d == PH_DUMP);
    end
  end

  assign pre_en_o   = pre_q;
  assign share_en_o = share_q;
  assign dump_en_o  = dump_q;
endmodule

// File: rtl/slog_adc_ctrl.sv
module slog_adc_ctrl #(
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PRE_CYC     = 4,
  parameter int SHARE_CYC   = 2,
  parameter int DUMP_CYC    = 3,
  parameter int GAP_CYC     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_stb_i,
  input  logic              sign_cmp_i,
  input  logic              mag_cmp_i,
  output logic              precharge_en_o,
  output logic              share_en_o,
  output logic              discharge_en_o,
  output logic [CODE_W:0]   code_o,
  output logic              code_vld_o
);
  localparam int OUT_W = CODE_W + 1;

  logic              rst_n_int;
  logic [1:0]        cmp_s;
  logic              sign_s, trip_s;
  logic              accept, eval, eval_pre, go_on, finish;
  logic [CODE_W-1:0] cnt;
  logic              at_max;
  logic              sign_q, sign_now;
  logic [OUT_W-1:0]  code_q, code_d;
  logic              vld_q;

  slog_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_int)
  );

  slog_sync #(.W(2), .STAGES(SYNC_STAGES)) u_cmp_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d_i   ({sign_cmp_i, mag_cmp_i}),
    .q_o   (cmp_s)
  );

  assign sign_s = cmp_s[1];
  assign trip_s = cmp_s[0];
  assign go_on  = !trip_s && !at_max;
  assign finish = eval && !go_on;

  slog_phase_seq #(
    .PRE_CYC   (PRE_CYC),
    .SHARE_CYC (SHARE_CYC),
    .DUMP_CYC  (DUMP_CYC),
    .GAP_CYC   (GAP_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .start_i    (sample_stb_i),
    .cont_i     (go_on),
    .accept_o   (accept),
    .eval_o     (eval),
    .eval_pre_o (eval_pre),
    .pre_en_o   (precharge_en_o),
    .share_en_o (share_en_o),
    .dump_en_o  (discharge_en_o)
  );

  slog_step_cnt #(.W(CODE_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .clr_i    (accept),
    .inc_i    (eval && go_on),
    .cnt_o    (cnt),
    .at_max_o (at_max)
  );

  // Sign is taken once the held input has settled through the synchronizer
  assign sign_now = eval_pre ? sign_s : sign_q;

  always_comb begin
    code_d = code_q;
    if (finish) code_d = {sign_now, cnt};
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      sign_q <= 1'b0;
      code_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      if (eval_pre) sign_q <= sign_s;
      if (finish)   code_q <= code_d;
      vld_q <= finish;
    end
  end

  assign code_o     = code_q;
  assign code_vld_o = vld_q;
endmodule

// File: rtl/slog_adc_ctrl_chk.sv
module slog_adc_ctrl_chk #(
  parameter int CODE_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            precharge_en_o,
  input logic            share_en_o,
  input logic            discharge_en_o,
  input logic [CODE_W:0] code_o,
  input logic            code_vld_o
);
  logic [CODE_W:0] n_shr_q;
  logic            pre_prev_q, shr_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_shr_q    <= '0;
      pre_prev_q <= 1'b0;
      shr_prev_q <= 1'b0;
    end else begin
      pre_prev_q <= precharge_en_o;
      shr_prev_q <= share_en_o;
      if (precharge_en_o && !pre_prev_q)  n_shr_q <= '0;
      else if (share_en_o && !shr_prev_q) n_shr_q <= n_shr_q + 1'b1;
    end
  end

  AST_SHARE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    share_en_o |-> !(precharge_en_o || discharge_en_o)); // R3
  AST_SHARE_TAIL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(share_en_o) |-> !(precharge_en_o || discharge_en_o)); // R3
  AST_SHARE_HEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(share_en_o) |-> !$past(precharge_en_o || discharge_en_o)); // R3
  AST_PRE_WITH_DUMP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(precharge_en_o) |-> discharge_en_o); // R2
  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    code_vld_o |=> !code_vld_o); // R7
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !code_vld_o |-> $stable(code_o)); // R7
  AST_CODE_EQ_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    code_vld_o |-> (n_shr_q == {1'b0, code_o[CODE_W-1:0]})); // R4
endmodule

bind slog_adc_ctrl slog_adc_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .precharge_en_o (precharge_en_o),
  .share_en_o     (share_en_o),
  .discharge_en_o (discharge_en_o),
  .code_o         (code_o),
  .code_vld_o     (code_vld_o)
);

// File: tb/slog_adc_ctrl_bench.sv
module slog_adc_ctrl_bench;
  localparam int  CW      = 8;
  localparam int  MAXC    = (1 << CW) - 1;
  localparam int  PRE_CYC = 4;
  localparam real D       = 0.9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sample_stb_i = 1'b0;
  logic          sign_cmp_i = 1'b0;
  logic          mag_cmp_i = 1'b0;
  logic          precharge_en_o, share_en_o, discharge_en_o, code_vld_o;
  logic [CW:0]   code_o;

  int  n_vec = 0, n_bad = 0;
  int  n_share = 0, n_pre = 0, n_vld = 0, n_ovl = 0;
  logic [CW:0] got_code = '0;
  real vcap = 1.0, xmag = 1.0;
  bit  xneg = 1'b0, shr_prev = 1'b0;

  slog_adc_ctrl #(.CODE_W(CW)) u_slog_adc_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .sample_stb_i   (sample_stb_i),
    .sign_cmp_i     (sign_cmp_i),
    .mag_cmp_i      (mag_cmp_i),
    .precharge_en_o (precharge_en_o),
    .share_en_o     (share_en_o),
    .discharge_en_o (discharge_en_o),
    .code_o         (code_o),
    .code_vld_o     (code_vld_o)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_mag(input real x);
    real v = 1.0;
    for (int k = 0; k < MAXC; k++) begin
      if (v <= x) return k;
      v = v * D;
    end
    return MAXC;
  endfunction

  // Analog model of master capacitor and comparators
  initial begin
    forever begin
      @(negedge clk);
      if (precharge_en_o) begin
        vcap = 1.0;
        n_pre++;
      end else if (share_en_o && !shr_prev) begin
        vcap = vcap * D;
        n_share++;
      end
      if (share_en_o && (precharge_en_o || discharge_en_o)) n_ovl++;
      if (code_vld_o) begin
        n_vld++;
        got_code = code_o;
      end
      shr_prev   = share_en_o;
      mag_cmp_i  = (vcap <= xmag);
      sign_cmp_i = xneg;
    end
  end

  task automatic run_conv(input real x, input bit neg, input bit extra, input string tag);
    int exp;
    int waitc;
    exp = exp_mag(x);
    @(negedge clk); #1;
    xmag = x;
    xneg = neg;
    repeat (4) @(negedge clk);
    #1;
    n_share = 0; n_pre = 0; n_vld = 0; n_ovl = 0;
    sample_stb_i = 1'b1;
    @(negedge clk); #1;
    chk(precharge_en_o && discharge_en_o, "R2 precharge+discharge after strobe", int'(precharge_en_o), 1);
    sample_stb_i = 1'b0;
    if (extra) begin
      repeat (5) @(negedge clk);
      #1;
      sample_stb_i = 1'b1;
      @(negedge clk); #1;
      sample_stb_i = 1'b0;
    end
    waitc = 0;
    while (n_vld == 0 && waitc < 6000) begin
      @(negedge clk); #1;
      waitc++;
    end
    repeat (3) @(negedge clk);
    #1;
    chk(n_vld == 1, {tag, " R7 R8 one result per conversion"}, n_vld, 1);
    chk(int'(got_code[CW-1:0]) == exp, {tag, " R4 R5 R9 magnitude code"}, int'(got_code[CW-1:0]), exp);
    chk(n_share == exp, {tag, " R4 share pulses"}, n_share, exp);
    chk(got_code[CW] == neg, {tag, " R6 sign bit"}, int'(got_code[CW]), int'(neg));
    chk(code_o == got_code, {tag, " R7 code held"}, int'(code_o), int'(got_code));
    chk(n_pre == PRE_CYC, {tag, " R2 R8 precharge cycles"}, n_pre, PRE_CYC);
    chk(n_ovl == 0, {tag, " R3 phase overlap"}, n_ovl, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    real vk, x, frac;
    int  k;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    #1;
    // R1 reset state
    chk(!precharge_en_o && !share_en_o && !discharge_en_o, "R1 enables in reset", 0, 0);
    chk(code_vld_o == 1'b0 && code_o == '0, "R1 code in reset", int'(code_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(!precharge_en_o && !code_vld_o && code_o == '0, "R1 after release", int'(code_o), 0);

    // Directed corners
    run_conv(1.0, 1'b0, 1'b0, "R9 full scale");
    run_conv(1.7, 1'b1, 1'b0, "R9 over range");
    run_conv(0.0, 1'b0, 1'b0, "R5 zero saturate");
    run_conv(1.0e-20, 1'b1, 1'b1, "R5 tiny saturate");
    vk = 1.0;
    for (int i = 0; i < 5; i++) vk = vk * D;
    run_conv(vk, 1'b0, 1'b0, "R4 exact d^5");
    run_conv(vk * 1.0001, 1'b1, 1'b0, "R4 above d^5");
    run_conv(vk * 0.9999, 1'b0, 1'b1, "R8 below d^5 with extra strobe");
    run_conv(D * 1.00001, 1'b1, 1'b1, "R8 just above d with extra strobe");

    // Random log-scaled inputs
    for (int n = 0; n < 30; n++) begin
      k = $urandom_range(0, 280);
      frac = real'($urandom_range(1, 999)) / 1000.0;
      vk = 1.0;
      for (int i = 0; i < k; i++) vk = vk * D;
      x = vk * (D + (1.0 - D) * frac);
      run_conv(x, 1'($urandom_range(0, 1)), (exp_mag(x) >= 1) && ($urandom_range(0, 3) == 0), "R4 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule